// File: doc/BRIEF.md
# Sampling Handshake Clock-Domain Bridge

This block carries data words from a fast source clock domain into a much slower destination clock domain. It does not try to deliver every word. When the source presents a valid word and the bridge is idle, the bridge latches that word into a holding register. The holding register then stays frozen while a four-phase request/acknowledge exchange runs between the two domains. Any words offered during that time are discarded. The result is a subsampled copy of a fast stream, for example a status byte produced at 100 MHz and read at 15 MHz.

Only two single-bit control lines cross between the domains. The request goes towards the destination and the acknowledge comes back, each through a multi-flop synchronizer. The data bus crosses without synchronizers. The destination reads the held word only after the synchronized request has arrived, which guarantees the word has been stable for several destination cycles. The destination presents each delivered word on a registered output with a one-cycle valid pulse. The source side exposes a busy level, so upstream logic can tell when an offered word will be taken.

Each domain has its own synchronous, active-high reset.

Top module: `cdc_sample_bridge`

## Requirements
- R1: After reset, srcBusy is 0, dstValid is 0 and dstData is all zeros.
- R2: A word is captured when srcValid is 1 at a srcClk rising edge while srcBusy is 0. srcBusy reads 1 from the next srcClk cycle on.
- R3: While srcBusy stays 1, the holding register keeps the captured word unchanged, whatever appears on srcData.
- R4: Words offered with srcValid while srcBusy is 1 are dropped. The destination output sequence equals exactly the sequence of captured words, in order.
- R5: The request stays asserted until the acknowledge has come back through the source synchronizer. Every captured word is therefore delivered exactly once, for any clock ratio. Only the request and acknowledge cross the domains, each through SYNC_STAGES flops.
- R6: dstValid is high for exactly one dstClk cycle per delivered word. dstData changes only in a cycle in which dstValid is 1.
- R7: The handshake is four-phase. The destination raises its acknowledge only after seeing the synchronized request, and delivery happens while srcBusy is still 1. srcBusy returns to 0 only after both the request and the synchronized acknowledge are low. On a continuous input stream, a new capture follows each completed exchange.
- R8: The delivered dstData equals the captured srcData bit for bit, for every 8-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source domain clock |
| srcRst | input | 1 | Source domain synchronous active-high reset |
| srcValid | input | 1 | Source word qualifier |
| srcData | input | DATA_W | Source word |
| srcBusy | output | 1 | High from capture until the handshake is back at idle |
| dstClk | input | 1 | Destination domain clock |
| dstRst | input | 1 | Destination domain synchronous active-high reset |
| dstValid | output | 1 | One-cycle pulse marking a delivered word |
| dstData | output | DATA_W | Registered delivered word |

## Verification
A sweep sends all 256 byte values one at a time, each offered while the bridge is idle. This separates data corruption (any bit error shows on R8) from handshake faults. On alternate words the sweep also drives different garbage words while busy is high, which exposes a holding register that reloads during a transfer. A continuous stream with srcValid held high on every source cycle stresses the drop path. The bench model records only the words offered while busy is low, so an output sequence with an extra, missing or reordered word is told apart from a correct subsampled stream. The capture count on that stream is bounded from both sides, which catches a bridge that stalls and one that skips the return-to-zero phases.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  // Strobes from the source-side control to the datapath
  typedef struct packed {
    logic loadHold;
  } srcStrobe_t;

  // Strobes from the destination-side control to the datapath
  typedef struct packed {
    logic loadOut;
    logic pulseValid;
  } dstStrobe_t;

  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_REQ   = 2'd1,
    SRC_DRAIN = 2'd2
  } srcState_e;

  typedef enum logic {
    DST_WAIT = 1'b0,
    DST_ACK  = 1'b1
  } dstState_e;

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/bridge_src_ctrl.sv
module bridge_src_ctrl
  import bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       srcValid,
  input  logic       ackSync,
  output logic       reqOut,
  output logic       busy,
  output srcStrobe_t strobe
);

  srcState_e state, nextState;
  logic      reqFlop;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      SRC_IDLE: begin
        if (srcValid) begin
          strobe.loadHold = 1'b1;
          nextState       = SRC_REQ;
        end
      end
      SRC_REQ: begin
        if (ackSync) nextState = SRC_DRAIN;
      end
      SRC_DRAIN: begin
        if (!ackSync) nextState = SRC_IDLE;
      end
      default: nextState = SRC_IDLE;
    endcase
  end

  // Request comes straight from a flop so the crossing line never glitches
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SRC_IDLE;
      reqFlop <= 1'b0;
    end else begin
      state   <= nextState;
      reqFlop <= (nextState == SRC_REQ);
    end
  end

  assign reqOut = reqFlop;
  assign busy   = (state != SRC_IDLE);

endmodule

// File: rtl/bridge_dst_ctrl.sv
module bridge_dst_ctrl
  import bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqSync,
  output logic       ackOut,
  output dstStrobe_t strobe
);

  dstState_e state, nextState;
  logic      ackFlop;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      DST_WAIT: begin
        if (reqSync) begin
          strobe.loadOut    = 1'b1;
          strobe.pulseValid = 1'b1;
          nextState         = DST_ACK;
        end
      end
      DST_ACK: begin
        if (!reqSync) nextState = DST_WAIT;
      end
      default: nextState = DST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= DST_WAIT;
      ackFlop <= 1'b0;
    end else begin
      state   <= nextState;
      ackFlop <= (nextState == DST_ACK);
    end
  end

  assign ackOut = ackFlop;

endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              srcClk,
  input  logic              srcRst,
  input  srcStrobe_t        srcStrobe,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] holdWord,
  input  logic              dstClk,
  input  logic              dstRst,
  input  dstStrobe_t        dstStrobe,
  output logic [DATA_W-1:0] dstData,
  output logic              dstValid
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] outReg;
  logic              validReg;

  // Source domain: enabled holding register
  always_ff @(posedge srcClk) begin
    if (srcRst)                  holdReg <= '0;
    else if (srcStrobe.loadHold) holdReg <= srcData;
  end

  // Destination domain: reads holdReg only after the synchronized request
  always_ff @(posedge dstClk) begin
    if (dstRst) begin
      outReg   <= '0;
      validReg <= 1'b0;
    end else begin
      if (dstStrobe.loadOut) outReg <= holdReg;
      validReg <= dstStrobe.pulseValid;
    end
  end

  assign holdWord = holdReg;
  assign dstData  = outReg;
  assign dstValid = validReg;

endmodule

// File: rtl/cdc_sample_bridge.sv
module cdc_sample_bridge
  import bridge_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRst,
  input  logic              srcValid,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcBusy,
  input  logic              dstClk,
  input  logic              dstRst,
  output logic              dstValid,
  output logic [DATA_W-1:0] dstData
);

  srcStrobe_t        srcStrobe;
  dstStrobe_t        dstStrobe;
  logic              reqLine;
  logic              ackLine;
  logic              reqAtDst;
  logic              ackAtSrc;
  logic [DATA_W-1:0] holdWord;

  bridge_src_ctrl src_ctrl_i (
    .clk      (srcClk),
    .rst      (srcRst),
    .srcValid (srcValid),
    .ackSync  (ackAtSrc),
    .reqOut   (reqLine),
    .busy     (srcBusy),
    .strobe   (srcStrobe)
  );

  bridge_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk  (dstClk),
    .rst  (dstRst),
    .din  (reqLine),
    .dout (reqAtDst)
  );

  bridge_dst_ctrl dst_ctrl_i (
    .clk     (dstClk),
    .rst     (dstRst),
    .reqSync (reqAtDst),
    .ackOut  (ackLine),
    .strobe  (dstStrobe)
  );

  bridge_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
    .clk  (srcClk),
    .rst  (srcRst),
    .din  (ackLine),
    .dout (ackAtSrc)
  );

  bridge_datapath #(.DATA_W(DATA_W)) dp_i (
    .srcClk    (srcClk),
    .srcRst    (srcRst),
    .srcStrobe (srcStrobe),
    .srcData   (srcData),
    .holdWord  (holdWord),
    .dstClk    (dstClk),
    .dstRst    (dstRst),
    .dstStrobe (dstStrobe),
    .dstData   (dstData),
    .dstValid  (dstValid)
  );

endmodule

// File: rtl/cdc_sample_bridge_chk.sv
module cdc_sample_bridge_chk #(
  parameter int DATA_W = 8
) (
  input logic              srcClk,
  input logic              srcRst,
  input logic              srcValid,
  input logic [DATA_W-1:0] srcData,
  input logic              srcBusy,
  input logic              dstClk,
  input logic              dstRst,
  input logic              dstValid,
  input logic [DATA_W-1:0] dstData,
  input logic              reqLine,
  input logic              ackLine,
  input logic              reqAtDst,
  input logic              ackAtSrc,
  input logic [DATA_W-1:0] holdWord
);

  AST_CAPTURE_ARMS: assert property (@(posedge srcClk) disable iff (srcRst)
    (srcValid && !srcBusy) |=> (srcBusy && holdWord == $past(srcData))); // R2

  AST_HOLD_FROZEN: assert property (@(posedge srcClk) disable iff (srcRst)
    (srcBusy && $past(srcBusy)) |-> $stable(holdWord)); // R3

  AST_REQ_LEVEL: assert property (@(posedge srcClk) disable iff (srcRst)
    (reqLine && !ackAtSrc) |=> reqLine); // R5

  AST_REQ_IN_BUSY: assert property (@(posedge srcClk) disable iff (srcRst)
    reqLine |-> srcBusy); // R7

  AST_IDLE_CLEAN: assert property (@(posedge srcClk) disable iff (srcRst)
    $fell(srcBusy) |-> (!reqLine && !ackAtSrc)); // R7

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge dstClk) disable iff (dstRst)
    $rose(ackLine) |-> $past(reqAtDst)); // R7

  AST_VALID_PULSE: assert property (@(posedge dstClk) disable iff (dstRst)
    dstValid |=> !dstValid); // R6

  AST_OUT_STEADY: assert property (@(posedge dstClk) disable iff (dstRst)
    !dstValid |-> $stable(dstData)); // R6

endmodule

bind cdc_sample_bridge cdc_sample_bridge_chk #(.DATA_W(DATA_W)) chk_i (
  .srcClk   (srcClk),
  .srcRst   (srcRst),
  .srcValid (srcValid),
  .srcData  (srcData),
  .srcBusy  (srcBusy),
  .dstClk   (dstClk),
  .dstRst   (dstRst),
  .dstValid (dstValid),
  .dstData  (dstData),
  .reqLine  (reqLine),
  .ackLine  (ackLine),
  .reqAtDst (reqAtDst),
  .ackAtSrc (ackAtSrc),
  .holdWord (holdWord)
);

// File: tb/cdc_sample_bridge_tb_top.sv
`timescale 1ns/100ps
module cdc_sample_bridge_tb_top;

  localparam int DATA_W  = 8;
  localparam int QD      = 4096;
  localparam int STREAM  = 3000;

  logic              srcClk = 1'b0;
  logic              dstClk = 1'b0;
  logic              srcRst = 1'b1;
  logic              dstRst = 1'b1;
  logic              srcValid = 1'b0;
  logic [DATA_W-1:0] srcData = '0;
  logic              srcBusy;
  logic              dstValid;
  logic [DATA_W-1:0] dstData;

  always #2.5  srcClk = ~srcClk;   // 200 MHz source
  always #16.5 dstClk = ~dstClk;   // slow destination

  cdc_sample_bridge #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut_i (
    .srcClk   (srcClk),
    .srcRst   (srcRst),
    .srcValid (srcValid),
    .srcData  (srcData),
    .srcBusy  (srcBusy),
    .dstClk   (dstClk),
    .dstRst   (dstRst),
    .dstValid (dstValid),
    .dstData  (dstData)
  );

  int errors = 0;
  int checks = 0;
  int wrPtr = 0;
  int rdPtr = 0;
  int phase = 0;
  logic [DATA_W-1:0] expQ [QD];
  bit   busyPending = 1'b0;
  logic prevValid = 1'b0;
  logic [DATA_W-1:0] prevData = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Source model: inputs change just after posedge, so at negedge the
  // values seen here are exactly those the next rising edge decides on.
  always @(negedge srcClk) begin
    if (!srcRst) begin
      if (busyPending) begin
        check(srcBusy == 1'b1, "R2 busy after capture", int'(srcBusy), 1);
        busyPending = 1'b0;
      end
      if (srcValid && !srcBusy) begin
        expQ[wrPtr % QD] = srcData;
        wrPtr++;
        busyPending = 1'b1;
      end
    end
  end

  // Destination monitor
  always @(negedge dstClk) begin
    if (!dstRst) begin
      if (dstValid) begin
        check(!prevValid, "R6 single-cycle valid", int'(prevValid), 0);
        check(srcBusy == 1'b1, "R7 delivery while busy", int'(srcBusy), 1);
        if (rdPtr < wrPtr) begin
          check(dstData == expQ[rdPtr % QD],
                (phase == 1) ? "R3 R8 delivered word" : "R4 subsampled word",
                int'(dstData), int'(expQ[rdPtr % QD]));
        end else begin
          check(1'b0, "R5 word with no capture", int'(dstData), -1);
        end
        rdPtr++;
      end else if (prevValid || dstData != prevData) begin
        check(dstData == prevData, "R6 data change without valid", int'(dstData), int'(prevData));
      end
      prevValid = dstValid;
      prevData  = dstData;
    end
  end

  task automatic waitIdle();
    do @(negedge srcClk); while (srcBusy);
  endtask

  task automatic drain();
    waitIdle();
    repeat (12) @(posedge dstClk);
    waitIdle();
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge srcClk);
    errors++;
    checks++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int startW;
    int captured;
    repeat (6) @(posedge dstClk);
    @(posedge srcClk); #1 srcRst = 1'b0;
    @(posedge dstClk); #1 dstRst = 1'b0;

    // R1: reset state
    @(negedge srcClk);
    check(srcBusy == 1'b0, "R1 busy after reset", int'(srcBusy), 0);
    @(negedge dstClk);
    check(dstValid == 1'b0, "R1 valid after reset", int'(dstValid), 0);
    check(dstData == '0, "R1 data after reset", int'(dstData), 0);

    // Phase 1: every byte value, with garbage offered while busy (R3, R8)
    phase = 1;
    for (int v = 0; v < 256; v++) begin
      waitIdle();
      @(posedge srcClk); #1 srcValid = 1'b1; srcData = DATA_W'(v);
      @(posedge srcClk); #1;
      if (v % 2 == 1) begin
        srcData = ~DATA_W'(v);
        repeat (3) @(posedge srcClk);
        #1;
      end
      srcValid = 1'b0;
      srcData  = 8'hA5;
    end
    drain();
    check(wrPtr == 256, "R8 captures in sweep", wrPtr, 256);
    check(rdPtr == wrPtr, "R5 deliveries in sweep", rdPtr, wrPtr);

    // Phase 2: continuous stream, most words dropped (R4, R7)
    phase = 2;
    startW = wrPtr;
    for (int i = 0; i < STREAM; i++) begin
      @(posedge srcClk); #1 srcValid = 1'b1; srcData = DATA_W'(i * 7 + 3);
    end
    @(posedge srcClk); #1 srcValid = 1'b0;
    drain();
    captured = wrPtr - startW;
    check(rdPtr == wrPtr, "R5 deliveries in stream", rdPtr, wrPtr);
    check(captured >= STREAM / 80, "R7 re-arm rate low bound", captured, STREAM / 80);
    check(captured <= STREAM / 20, "R4 drop rate high bound", captured, STREAM / 20);

    // Phase 3: single word after the stream
    phase = 3;
    startW = wrPtr;
    @(posedge srcClk); #1 srcValid = 1'b1; srcData = 8'h5C;
    @(posedge srcClk); #1 srcValid = 1'b0;
    drain();
    check(wrPtr - startW == 1, "R2 single capture", wrPtr - startW, 1);
    check(dstData == 8'h5C, "R8 final word", int'(dstData), 'h5C);
    check(srcBusy == 1'b0, "R7 back to idle", int'(srcBusy), 0);

    finishRun();
  end

endmodule